// File: doc/BRIEF.md
# Asynchronous External Bus Master

This block carries out one read or one write at a time on an external asynchronous parallel bus for a processor core. The core presents a request with a 20-bit byte address, a direction, an operand size (byte or word) and write data. The block then runs the strobe sequence on the pins, waits for the external device to terminate the cycle, and returns a one-clock done pulse. An error flag rides on that pulse when the cycle ended on a bus error. Read data is returned on a held output.

The block uses one clock. One clock period is one half-period of the external bus timing, so every strobe edge lands on a clock edge and no second clock edge or phase generator is needed. The acknowledge and bus-error inputs are active low and asynchronous. Each passes through a synchroniser of parameterised depth before the sequencer acts on it. While a cycle is running, a busy flag holds off new requests. After every cycle the block spends at least one clock back in idle.

Top module: `xbus_master`

## Requirements
- R1: After reset, as_n and ds_n are high, data_oe is low, rw is high, and busy, done and err are low.
- R2: On the clock edge that accepts a request, bus_addr[19:0] takes req_addr and bus_addr[23:20] take the value of req_addr[19]. rw is set to 1 for a read (req_write=0) and to 0 for a write (req_write=1). bus_addr does not change while as_n is low.
- R3: as_n falls exactly one clock after the edge that drove the address.
- R4: On a read, ds_n falls on the same edge as as_n.
- R5: On a write, data_oe rises one clock after as_n falls, and ds_n falls two clocks after as_n falls.
- R6: On a write, all 16 lines of data_o are driven. For req_size=1 (word), data_o equals req_wdata. For req_size=0 (byte), data_o is {req_wdata[7:0], req_wdata[7:0]}.
- R7: A read that ends without a bus error loads rdata on its terminating edge. For a word read, rdata takes data_i. For a byte read, the more significant lane data_i[15:8] is used when req_addr[0]=0 and data_i[7:0] when req_addr[0]=1. The chosen byte goes in rdata[7:0] and rdata[15:8] is zero. rdata is otherwise held, including after writes and after reads that end in error.
- R8: An acknowledge (ack_n low) ends the cycle after two synchroniser clocks. If ack_n is first seen low at edge k, then at edge k+2 as_n and ds_n rise together, data_oe falls and done pulses high for one clock.
- R9: A bus error (berr_n low) ends the cycle with the same timing as R8, whether it arrives alone or together with ack_n low. err is high together with done, and only then.
- R10: A termination is acted on only after ds_n has been low for at least one clock. An acknowledge held low from the start of a write ends the cycle one clock after ds_n falls.
- R11: busy is high from the accepting edge until the block is back in idle, which is one clock after the terminating edge. A request that is raised and dropped while busy is high starts no cycle. as_n stays high for at least two clocks between cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is half a bus timing period |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 0 = byte, 1 = word |
| req_addr | input | 20 | Byte address of the most significant byte |
| req_wdata | input | 16 | Write operand (byte in bits 7:0) |
| busy | output | 1 | Cycle in progress or recovering |
| done | output | 1 | One-clock pulse at cycle end |
| err | output | 1 | Cycle ended on bus error (with done) |
| rdata | output | 16 | Last read result |
| bus_addr | output | 24 | External address, bits 23:20 copy bit 19 |
| data_o | output | 16 | External data out |
| data_oe | output | 1 | Data output enable (tri-state control) |
| data_i | input | 16 | External data in |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rw | output | 1 | 1 = read, 0 = write |
| ack_n | input | 1 | Transfer acknowledge, active low, asynchronous |
| berr_n | input | 1 | Bus error, active low, asynchronous |

## Verification
The bench checks the different strobe timing of reads and writes at every half-period step. A design that gave writes the read timing would raise the data strobe before the data is on the bus. It checks byte reads at even and odd addresses, where a swapped lane would return the wrong byte. It also checks that a byte write drives both halves and that addresses with bit 19 set sign-fill the top nibble. Bus error is exercised both alone and together with acknowledge. A design that let acknowledge win would drop the error flag or overwrite rdata with garbage. An acknowledge held low from the very start of a write must not cut the cycle short before the data strobe. A request raised only while the block is busy must start nothing.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ASRT,
    ST_WDAT,
    ST_WAIT,
    ST_REST
  } xbus_state_e;

  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_WORD = 1'b1
  } xbus_size_e;
endpackage

// File: rtl/xbus_sync.sv
module xbus_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {STAGES{RST_VAL}};
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/xbus_lane.sv
module xbus_lane
  import xbus_pkg::*;
#(
  parameter int DW = 16,
  localparam int LANES = DW / 8,
  localparam int LSB_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  xbus_size_e       size,
  input  logic [LSB_W-1:0] a_lo,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    data_i,
  output logic [DW-1:0]    wr_lanes,
  output logic [DW-1:0]    rd_lanes
);
  // write: a byte is copied onto every lane so the whole bus is driven
  always_comb begin
    if (size == SZ_WORD) wr_lanes = wdata;
    else                 wr_lanes = {LANES{wdata[7:0]}};
  end

  // read: lane 0 of the address sits in the most significant byte
  always_comb begin
    int idx;
    idx = LANES - 1 - int'(a_lo);
    rd_lanes = '0;
    if (size == SZ_WORD) rd_lanes = data_i;
    else                 rd_lanes[7:0] = data_i[idx*8 +: 8];
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int IN_AW  = 20,
  parameter int EXT_AW = 24,
  parameter int DW     = 16,
  localparam int LANES = DW / 8,
  localparam int LSB_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int PAD_W = EXT_AW - IN_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  xbus_size_e        req_size,
  input  logic [IN_AW-1:0]  req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic              ack_s,
  input  logic              berr_s,
  input  logic [DW-1:0]     wr_lanes,
  input  logic [DW-1:0]     rd_lanes,
  output xbus_size_e        size_q,
  output logic [LSB_W-1:0]  a_lo_q,
  output logic [DW-1:0]     wdata_q,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DW-1:0]     rdata,
  output logic [EXT_AW-1:0] bus_addr,
  output logic [DW-1:0]     data_o,
  output logic              data_oe,
  output logic              as_n,
  output logic              ds_n,
  output logic              rw
);
  xbus_state_e state;
  logic        term;

  assign term = ack_s | berr_s;
  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      as_n     <= 1'b1;
      ds_n     <= 1'b1;
      rw       <= 1'b1;
      data_oe  <= 1'b0;
      data_o   <= '0;
      bus_addr <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      rdata    <= '0;
      size_q   <= SZ_BYTE;
      a_lo_q   <= '0;
      wdata_q  <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            bus_addr <= {{PAD_W{req_addr[IN_AW-1]}}, req_addr};
            rw       <= ~req_write;
            size_q   <= req_size;
            a_lo_q   <= req_addr[LSB_W-1:0];
            wdata_q  <= req_wdata;
            state    <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          as_n <= 1'b0;
          if (rw) begin
            ds_n  <= 1'b0;
            state <= ST_WAIT;
          end else begin
            state <= ST_ASRT;
          end
        end
        ST_ASRT: begin
          data_oe <= 1'b1;
          data_o  <= wr_lanes;
          state   <= ST_WDAT;
        end
        ST_WDAT: begin
          ds_n  <= 1'b0;
          state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (term) begin
            as_n    <= 1'b1;
            ds_n    <= 1'b1;
            data_oe <= 1'b0;
            done    <= 1'b1;
            err     <= berr_s;
            if (rw && !berr_s) rdata <= rd_lanes;
            state   <= ST_REST;
          end
        end
        ST_REST: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xbus_master.sv
module xbus_master
  import xbus_pkg::*;
#(
  parameter int IN_AW       = 20,
  parameter int EXT_AW      = 24,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2,
  localparam int LANES = DW / 8,
  localparam int LSB_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_size,
  input  logic [IN_AW-1:0]  req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DW-1:0]     rdata,
  output logic [EXT_AW-1:0] bus_addr,
  output logic [DW-1:0]     data_o,
  output logic              data_oe,
  input  logic [DW-1:0]     data_i,
  output logic              as_n,
  output logic              ds_n,
  output logic              rw,
  input  logic              ack_n,
  input  logic              berr_n
);
  logic             ack_q, berr_q;
  xbus_size_e       size_q;
  logic [LSB_W-1:0] a_lo_q;
  logic [DW-1:0]    wdata_q, wr_lanes, rd_lanes;

  xbus_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ack_sync (
    .clk(clk), .rst(rst), .d(ack_n), .q(ack_q)
  );

  xbus_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_berr_sync (
    .clk(clk), .rst(rst), .d(berr_n), .q(berr_q)
  );

  xbus_lane #(.DW(DW)) u_lane (
    .size(size_q), .a_lo(a_lo_q), .wdata(wdata_q), .data_i(data_i),
    .wr_lanes(wr_lanes), .rd_lanes(rd_lanes)
  );

  xbus_seq #(.IN_AW(IN_AW), .EXT_AW(EXT_AW), .DW(DW)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_size(xbus_size_e'(req_size)), .req_addr(req_addr), .req_wdata(req_wdata),
    .ack_s(~ack_q), .berr_s(~berr_q),
    .wr_lanes(wr_lanes), .rd_lanes(rd_lanes),
    .size_q(size_q), .a_lo_q(a_lo_q), .wdata_q(wdata_q),
    .busy(busy), .done(done), .err(err), .rdata(rdata),
    .bus_addr(bus_addr), .data_o(data_o), .data_oe(data_oe),
    .as_n(as_n), .ds_n(ds_n), .rw(rw)
  );
endmodule

// File: rtl/xbus_master_chk.sv
module xbus_master_chk #(
  parameter int IN_AW  = 20,
  parameter int EXT_AW = 24
) (
  input logic              clk,
  input logic              rst,
  input logic [EXT_AW-1:0] bus_addr,
  input logic              as_n,
  input logic              ds_n,
  input logic              rw,
  input logic              data_oe,
  input logic              done,
  input logic              err,
  input logic              busy
);
  // R2
  addr_ext_chk: assert property (@(posedge clk) disable iff (rst)
    bus_addr[EXT_AW-1:IN_AW] == {(EXT_AW-IN_AW){bus_addr[IN_AW-1]}});
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!as_n && !$past(as_n)) |-> $stable(bus_addr));
  // R4
  rd_ds_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(as_n) && rw) |-> !ds_n);
  // R5
  wr_ds_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(as_n) && !rw) |-> (ds_n && !data_oe) ##1 (data_oe && ds_n) ##1 !ds_n);
  // R8
  end_pair_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(as_n) |-> ($rose(ds_n) && !data_oe && done));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
  // R10
  ds_before_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !$past(ds_n));
  // R11
  idle_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(as_n) |-> $past(as_n, 2));
  // R11
  busy_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !as_n |-> busy);
endmodule

bind xbus_master xbus_master_chk #(.IN_AW(IN_AW), .EXT_AW(EXT_AW)) u_chk (.*);

// File: tb/xbus_master_bench.sv
`timescale 1ns/1ps
module xbus_master_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_size = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, err;
  logic [15:0] rdata;
  logic [23:0] bus_addr;
  logic [15:0] data_o;
  logic        data_oe;
  logic [15:0] data_i = '0;
  logic        as_n, ds_n, rw;
  logic        ack_n = 1'b1, berr_n = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] exp_rd = '0;

  always #10 clk = ~clk;

  xbus_master u_xbus_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .err(err), .rdata(rdata),
    .bus_addr(bus_addr), .data_o(data_o), .data_oe(data_oe), .data_i(data_i),
    .as_n(as_n), .ds_n(ds_n), .rw(rw), .ack_n(ack_n), .berr_n(berr_n)
  );

  function automatic logic [23:0] f_ext(input logic [19:0] a);
    return {{4{a[19]}}, a};
  endfunction

  function automatic logic [15:0] f_wl(input logic sz, input logic [15:0] w);
    return sz ? w : {w[7:0], w[7:0]};
  endfunction

  function automatic logic [15:0] f_rl(input logic sz, input logic a0, input logic [15:0] d);
    if (sz) return d;
    return a0 ? {8'h00, d[7:0]} : {8'h00, d[15:8]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // mode: 0 ack, 1 bus error alone, 2 both
  task automatic run_cycle(input bit wr, input bit sz, input logic [19:0] a,
                           input logic [15:0] wd, input int dly, input int mode,
                           input bit poke, input bit early);
    logic [15:0] rd_bus;
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(bus_addr == f_ext(a), "R2 address", bus_addr, f_ext(a));
    chk(rw == !wr, "R2 rw", rw, !wr);
    chk(as_n == 1'b1, "R3 as_n not before one clock", as_n, 1);
    chk(busy == 1'b1, "R11 busy", busy, 1);
    if (early) ack_n = 1'b0;
    @(negedge clk);
    chk(as_n == 1'b0, "R3 as_n asserted", as_n, 0);
    if (!wr) chk(ds_n == 1'b0, "R4 read ds_n with as_n", ds_n, 0);
    else     chk(ds_n && !data_oe, "R5 write ds_n/oe idle", {ds_n, data_oe}, 2'b10);
    if (wr) begin
      @(negedge clk);
      chk(data_oe && ds_n, "R5 oe before ds", {ds_n, data_oe}, 2'b11);
      chk(data_o == f_wl(sz, wd), "R6 write lanes", data_o, f_wl(sz, wd));
      @(negedge clk);
      chk(!ds_n && !as_n, "R5 ds_n after full clock", {as_n, ds_n}, 2'b00);
    end
    if (early) begin
      @(negedge clk);
      chk(as_n && ds_n && done, "R10 early ack ends after ds", {as_n, ds_n, done}, 3'b111);
      ack_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done, "R11 idle after early", {busy, done}, 0);
      return;
    end
    for (int i = 0; i < dly; i++) begin
      if (poke && i == 0) begin req_valid = 1'b1; req_addr = ~a; end
      if (i == 1) req_valid = 1'b0;
      @(negedge clk);
      chk(!as_n && !done, "R8 held without ack", {as_n, done}, 0);
    end
    req_valid = 1'b0;
    rd_bus = 16'($urandom);
    data_i = rd_bus;
    ack_n  = (mode != 1) ? 1'b0 : 1'b1;
    berr_n = (mode != 0) ? 1'b0 : 1'b1;
    @(negedge clk);
    chk(!as_n, "R8 sync stage 1", as_n, 0);
    @(negedge clk);
    chk(!as_n, "R8 sync stage 2", as_n, 0);
    @(negedge clk);
    chk(as_n && ds_n && !data_oe, "R8 strobes release", {as_n, ds_n, data_oe}, 3'b110);
    chk(done, "R8 done", done, 1);
    chk(err == (mode != 0), "R9 err flag", err, (mode != 0));
    if (!wr && mode == 0) exp_rd = f_rl(sz, a[0], rd_bus);
    chk(rdata == exp_rd, "R7 read data", rdata, exp_rd);
    ack_n = 1'b1; berr_n = 1'b1; data_i = 16'($urandom);
    @(negedge clk);
    chk(!done && !err, "R8 done one clock", {done, err}, 0);
    chk(!busy && as_n, "R11 idle gap", {busy, as_n}, 1);
    chk(bus_addr == f_ext(a), "R11 busy request ignored", bus_addr, f_ext(a));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(as_n && ds_n && rw && !data_oe, "R1 reset strobes", {as_n, ds_n, rw, data_oe}, 4'b1110);
    chk(!busy && !done && !err, "R1 reset status", {busy, done, err}, 0);
    // directed
    run_cycle(0, 1, 20'h12346, 16'h0, 0, 0, 0, 0);
    run_cycle(0, 0, 20'h80010, 16'h0, 1, 0, 0, 0);
    run_cycle(0, 0, 20'h80011, 16'h0, 2, 0, 0, 0);
    run_cycle(1, 0, 20'h00033, 16'hBEA5, 0, 0, 0, 0);
    run_cycle(1, 1, 20'hF0000, 16'hC3D2, 3, 0, 0, 0);
    run_cycle(0, 1, 20'h44440, 16'h0, 1, 1, 0, 0);
    run_cycle(0, 1, 20'h44442, 16'h0, 0, 2, 0, 0);
    run_cycle(1, 1, 20'h55550, 16'h1234, 0, 1, 0, 0);
    run_cycle(1, 1, 20'h9ABCE, 16'h7777, 0, 0, 0, 1);
    run_cycle(0, 1, 20'h01230, 16'h0, 3, 0, 1, 0);
    // idle window: nothing starts without a request
    repeat (3) begin
      @(negedge clk);
      chk(as_n && !busy, "R11 no spurious cycle", {as_n, busy}, 2'b10);
    end
    // random
    for (int n = 0; n < 60; n++) begin
      bit wr, sz, pk;
      int dl, md;
      wr = 1'($urandom);
      sz = 1'($urandom);
      dl = int'($urandom % 5);
      md = int'($urandom % 4);
      if (md == 3) md = 0;
      pk = (dl >= 2) && 1'($urandom);
      run_cycle(wr, sz, 20'($urandom), 16'($urandom), dl, md, pk, 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule